// File: doc/BRIEF.md
# Rolling Readout Sequencer for an Addressed Pixel Array

This controller drives a CMOS pixel array whose rows and columns are picked through binary decoders rather than shift registers. A single address bus feeds both decoders. A row-load strobe captures the bus into the row decoder, and a column-load strobe captures it into the column decoder. After a start command, the sequencer reads one frame row by row. For each row it loads the row address and pulses the row-connect strobe so that the row drives the column amplifiers. It waits a settle interval, then steps through every column. For each column it enables the ADC output drivers for one cycle and samples the 10-bit word.

After a row's column loop, the same bus is reused to reset a row that lies a programmed number of rows ahead of the read row. This rolling reset sets the integration time. When dual-slope mode is on, a second slot resets another row, again a programmed distance ahead, to the reference level. Each captured pixel leaves as a one-cycle valid beat. The beat carries the row and column index, a colour tag for the red/green/blue mosaic, a start-of-frame flag and an end-of-line flag.

The FSM states are IDLE, LATCH_Y, CONNECT, SETTLE, COL_SEL, COL_CAP, RST_LATCH, RST_PULSE, DS_LATCH and DS_PULSE. The transitions are:
- IDLE→LATCH_Y on start.
- LATCH_Y→CONNECT→SETTLE.
- SETTLE→COL_SEL after the settle count.
- COL_SEL→COL_CAP.
- COL_CAP→COL_SEL while columns remain, otherwise COL_CAP→RST_LATCH.
- RST_LATCH→RST_PULSE.
- RST_PULSE→DS_LATCH if dual-slope mode is on.
- DS_LATCH→DS_PULSE.
- From the last reset slot, go to LATCH_Y for the next row, or to IDLE after the final row.

Top module: `rolling_readout_seq`

## Requirements
- R1: After reset, every strobe, `adc_oe`, `busy` and `pix_valid` are low.
- R2: `start` is accepted only in IDLE. The configuration inputs are captured when `start` is accepted. A `start` pulse or a change to the configuration while busy has no effect on the running frame and is not queued.
- R3: Rows are read in ascending order, 0 to `cfg_last_row`. Each row begins with `y_load` carrying the row address, followed on the next cycle by `row_connect`, then `SETTLE_CYC` quiet cycles.
- R4: Columns are visited in ascending order, 0 to `cfg_last_col`. Each column takes one cycle with `x_load` and the column address, then one cycle with `adc_oe` high. `adc_data` is sampled only at the end of that `adc_oe` cycle.
- R5: After a row's column loop, `y_load` carries (read row + lead) modulo (`cfg_last_row`+1), and `row_clear` pulses on the next cycle. The lead must be at most `cfg_last_row`.
- R6: With dual-slope mode on, a second `y_load` carries (read row + dual lead) modulo the row count, followed by `row_clear_ref`. With the mode off, `row_clear_ref` never pulses.
- R7: `pix_valid` is high for one cycle, one cycle after each `adc_oe` cycle. It presents the sampled word together with that pixel's row and column.
- R8: `pix_color` is 0 (red) for even row and even column, 2 (blue) for odd row and odd column, and 1 (green) otherwise.
- R9: `pix_sof` is high only with pixel (0,0), and `pix_eol` is high only with the last column of each row.
- R10: `busy` is high from the cycle after `start` until the final reset slot of the last row. Each row period lasts 4 + `SETTLE_CYC` + 2·(`cfg_last_col`+1) cycles, plus 2 in dual-slope mode.
- R11: At most one of `y_load`, `x_load`, `row_connect`, `row_clear`, `row_clear_ref` and `adc_oe` is high in any cycle. Reset latching never falls inside a column loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request |
| cfg_last_row | input | ROW_W | Row count minus one |
| cfg_last_col | input | COL_W | Column count minus one |
| cfg_lead | input | ROW_W | Reset-to-read lead in rows |
| cfg_ds_lead | input | ROW_W | Dual-slope reset lead in rows |
| cfg_ds_en | input | 1 | Dual-slope mode enable |
| dec_addr | output | ADDR_W | Shared decoder address bus |
| y_load | output | 1 | Row decoder latch strobe |
| x_load | output | 1 | Column decoder latch strobe |
| row_connect | output | 1 | Connect latched row to column amplifiers |
| row_clear | output | 1 | Full reset of latched row |
| row_clear_ref | output | 1 | Reference-level reset of latched row |
| adc_oe | output | 1 | ADC output-driver enable |
| adc_data | input | DATA_W | ADC conversion word |
| busy | output | 1 | Frame in progress |
| pix_valid | output | 1 | Pixel beat valid |
| pix_data | output | DATA_W | Pixel value |
| pix_row | output | ROW_W | Pixel row index |
| pix_col | output | COL_W | Pixel column index |
| pix_color | output | 2 | Mosaic colour tag |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of row |

## Verification
The bench builds the block with ROW_W=3, COL_W=3 and SETTLE_CYC=3. It sweeps every row count from 2 to 4, every column count from 1 to 4, every reset lead from zero up to the last row, and dual-slope mode both off and on. This covers the wrap of both reset pointers, the single-column row where every pixel is an end of line, and both row-period lengths. One frame receives a stray start together with altered configuration in mid-run, to show that neither takes hold before the frame boundary.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LATCH_Y,
        ST_CONNECT,
        ST_SETTLE,
        ST_COL_SEL,
        ST_COL_CAP,
        ST_RST_LATCH,
        ST_RST_PULSE,
        ST_DS_LATCH,
        ST_DS_PULSE
    } seq_state_t;

    typedef enum logic [1:0] {
        CLR_RED   = 2'd0,
        CLR_GREEN = 2'd1,
        CLR_BLUE  = 2'd2
    } bayer_t;
endpackage

// File: rtl/rrs_row_wrap.sv
module rrs_row_wrap #(
    parameter int W = 4
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] lead,
    input  logic [W-1:0] last,
    output logic [W-1:0] row
);
    logic [W:0] sum;
    logic [W:0] span;
    logic [W:0] wrapped;

    always_comb begin
        sum     = {1'b0, base} + {1'b0, lead};
        span    = {1'b0, last} + (W+1)'(1);
        wrapped = (sum > {1'b0, last}) ? (sum - span) : sum;
        row     = wrapped[W-1:0];
    end
endmodule

// File: rtl/rrs_fsm.sv
module rrs_fsm
    import rrs_pkg::*;
#(
    parameter int ROW_W      = 4,
    parameter int COL_W      = 4,
    parameter int ADDR_W     = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_last_row,
    input  logic [COL_W-1:0]  cfg_last_col,
    input  logic [ROW_W-1:0]  cfg_lead,
    input  logic [ROW_W-1:0]  cfg_ds_lead,
    input  logic              cfg_ds_en,
    input  logic [ROW_W-1:0]  clr_row,
    input  logic [ROW_W-1:0]  ref_row,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [ROW_W-1:0]  last_row_q,
    output logic [COL_W-1:0]  last_col_q,
    output logic [ROW_W-1:0]  lead_q,
    output logic [ROW_W-1:0]  ds_lead_q,
    output logic              ds_en_q,
    output logic [ADDR_W-1:0] dec_addr,
    output logic              y_load,
    output logic              x_load,
    output logic              row_connect,
    output logic              row_clear,
    output logic              row_clear_ref,
    output logic              adc_oe,
    output logic              capture,
    output logic              busy
);
    localparam int SET_W = $clog2(SETTLE_CYC) + 1;

    seq_state_t state, nxt;
    logic [SET_W-1:0] set_q;
    logic             last_row_now;

    assign last_row_now = (row_q == last_row_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_LATCH_Y;
            ST_LATCH_Y:   nxt = ST_CONNECT;
            ST_CONNECT:   nxt = ST_SETTLE;
            ST_SETTLE:    if (set_q == SET_W'(SETTLE_CYC-1)) nxt = ST_COL_SEL;
            ST_COL_SEL:   nxt = ST_COL_CAP;
            ST_COL_CAP:   nxt = (col_q == last_col_q) ? ST_RST_LATCH : ST_COL_SEL;
            ST_RST_LATCH: nxt = ST_RST_PULSE;
            ST_RST_PULSE: nxt = ds_en_q ? ST_DS_LATCH
                              : (last_row_now ? ST_IDLE : ST_LATCH_Y);
            ST_DS_LATCH:  nxt = ST_DS_PULSE;
            ST_DS_PULSE:  nxt = last_row_now ? ST_IDLE : ST_LATCH_Y;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q      <= '0;
            col_q      <= '0;
            set_q      <= '0;
            last_row_q <= '0;
            last_col_q <= '0;
            lead_q     <= '0;
            ds_lead_q  <= '0;
            ds_en_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                row_q      <= '0;
                last_row_q <= cfg_last_row;
                last_col_q <= cfg_last_col;
                lead_q     <= cfg_lead;
                ds_lead_q  <= cfg_ds_lead;
                ds_en_q    <= cfg_ds_en;
            end else if (nxt == ST_LATCH_Y) begin
                row_q <= row_q + ROW_W'(1);
            end
            if (state == ST_CONNECT)     set_q <= '0;
            else if (state == ST_SETTLE) set_q <= set_q + SET_W'(1);
            if (state == ST_SETTLE)      col_q <= '0;
            else if (state == ST_COL_CAP && col_q != last_col_q)
                col_q <= col_q + COL_W'(1);
        end
    end

    always_comb begin
        dec_addr      = '0;
        y_load        = 1'b0;
        x_load        = 1'b0;
        row_connect   = 1'b0;
        row_clear     = 1'b0;
        row_clear_ref = 1'b0;
        adc_oe        = 1'b0;
        capture       = 1'b0;
        busy          = (state != ST_IDLE);
        unique case (state)
            ST_LATCH_Y:   begin dec_addr = ADDR_W'(row_q);   y_load = 1'b1; end
            ST_CONNECT:   row_connect = 1'b1;
            ST_COL_SEL:   begin dec_addr = ADDR_W'(col_q);   x_load = 1'b1; end
            ST_COL_CAP:   begin adc_oe = 1'b1; capture = 1'b1; end
            ST_RST_LATCH: begin dec_addr = ADDR_W'(clr_row); y_load = 1'b1; end
            ST_RST_PULSE: row_clear = 1'b1;
            ST_DS_LATCH:  begin dec_addr = ADDR_W'(ref_row); y_load = 1'b1; end
            ST_DS_PULSE:  row_clear_ref = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/rrs_pix_out.sv
module rrs_pix_out
    import rrs_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [COL_W-1:0]  last_col,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic [ROW_W-1:0]  pix_row,
    output logic [COL_W-1:0]  pix_col,
    output logic [1:0]        pix_color,
    output logic              pix_sof,
    output logic              pix_eol
);
    bayer_t color;

    always_comb begin
        unique case ({row[0], col[0]})
            2'b00:   color = CLR_RED;
            2'b11:   color = CLR_BLUE;
            default: color = CLR_GREEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_row   <= '0;
            pix_col   <= '0;
            pix_color <= '0;
            pix_sof   <= 1'b0;
            pix_eol   <= 1'b0;
        end else begin
            pix_valid <= capture;
            pix_sof   <= capture && row == '0 && col == '0;
            pix_eol   <= capture && col == last_col;
            if (capture) begin
                pix_data  <= adc_data;
                pix_row   <= row;
                pix_col   <= col;
                pix_color <= color;
            end
        end
    end
endmodule

// File: rtl/rolling_readout_seq.sv
module rolling_readout_seq #(
    parameter int ROW_W      = 4,
    parameter int COL_W      = 4,
    parameter int DATA_W     = 10,
    parameter int SETTLE_CYC = 2,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_last_row,
    input  logic [COL_W-1:0]  cfg_last_col,
    input  logic [ROW_W-1:0]  cfg_lead,
    input  logic [ROW_W-1:0]  cfg_ds_lead,
    input  logic              cfg_ds_en,
    output logic [ADDR_W-1:0] dec_addr,
    output logic              y_load,
    output logic              x_load,
    output logic              row_connect,
    output logic              row_clear,
    output logic              row_clear_ref,
    output logic              adc_oe,
    input  logic [DATA_W-1:0] adc_data,
    output logic              busy,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic [ROW_W-1:0]  pix_row,
    output logic [COL_W-1:0]  pix_col,
    output logic [1:0]        pix_color,
    output logic              pix_sof,
    output logic              pix_eol
);
    logic [ROW_W-1:0] row_q, last_row_q, lead_q, ds_lead_q, clr_row, ref_row;
    logic [COL_W-1:0] col_q, last_col_q;
    logic             frame_ds_en;
    logic             capture;

    rrs_row_wrap #(.W(ROW_W)) u_clr_wrap (
        .base(row_q), .lead(lead_q), .last(last_row_q), .row(clr_row)
    );

    rrs_row_wrap #(.W(ROW_W)) u_ref_wrap (
        .base(row_q), .lead(ds_lead_q), .last(last_row_q), .row(ref_row)
    );

    rrs_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_last_row(cfg_last_row), .cfg_last_col(cfg_last_col),
        .cfg_lead(cfg_lead), .cfg_ds_lead(cfg_ds_lead), .cfg_ds_en(cfg_ds_en),
        .clr_row(clr_row), .ref_row(ref_row),
        .row_q(row_q), .col_q(col_q), .last_row_q(last_row_q),
        .last_col_q(last_col_q), .lead_q(lead_q), .ds_lead_q(ds_lead_q),
        .ds_en_q(frame_ds_en), .dec_addr(dec_addr), .y_load(y_load),
        .x_load(x_load), .row_connect(row_connect), .row_clear(row_clear),
        .row_clear_ref(row_clear_ref), .adc_oe(adc_oe), .capture(capture),
        .busy(busy)
    );

    rrs_pix_out #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .capture(capture), .adc_data(adc_data),
        .row(row_q), .col(col_q), .last_col(last_col_q),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_row(pix_row),
        .pix_col(pix_col), .pix_color(pix_color), .pix_sof(pix_sof),
        .pix_eol(pix_eol)
    );
endmodule

// File: rtl/rrs_chk.sv
module rrs_chk (
    input logic clk,
    input logic rst_n,
    input logic y_load,
    input logic x_load,
    input logic row_connect,
    input logic row_clear,
    input logic row_clear_ref,
    input logic adc_oe,
    input logic busy,
    input logic pix_valid,
    input logic frame_ds_en
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({y_load, x_load, row_connect, row_clear, row_clear_ref, adc_oe}));

    // R3
    connect_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_connect |-> $past(y_load));

    // R5
    clear_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_clear |-> $past(y_load));

    // R6
    ref_clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_clear_ref |-> ($past(y_load) && frame_ds_en));

    // R4
    oe_follows_xload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_load |=> adc_oe);

    // R7
    valid_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(adc_oe));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(y_load || x_load || row_connect || row_clear || row_clear_ref || adc_oe));
endmodule

bind rolling_readout_seq rrs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .y_load(y_load), .x_load(x_load),
    .row_connect(row_connect), .row_clear(row_clear),
    .row_clear_ref(row_clear_ref), .adc_oe(adc_oe), .busy(busy),
    .pix_valid(pix_valid), .frame_ds_en(frame_ds_en)
);

// File: tb/sim_rolling_readout_seq.sv
module sim_rolling_readout_seq;
    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int DATA_W = 10;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROW_W-1:0] cfg_last_row = '0, cfg_lead = '0, cfg_ds_lead = '0;
    logic [COL_W-1:0] cfg_last_col = '0;
    logic cfg_ds_en = 1'b0;
    logic [2:0] dec_addr;
    logic y_load, x_load, row_connect, row_clear, row_clear_ref, adc_oe, busy;
    logic [DATA_W-1:0] adc_data, pix_data;
    logic pix_valid, pix_sof, pix_eol;
    logic [ROW_W-1:0] pix_row;
    logic [COL_W-1:0] pix_col;
    logic [1:0] pix_color;

    int checks = 0, failures = 0;
    int f_rows, f_cols, f_lead, f_dslead, f_ds;
    int ylat = 0, xlat = 0, conn = 0;
    int exp_rrow, exp_xcol, exp_pr, exp_pc;
    int n_pix, n_clr, n_ds, n_busy, n_sof, n_eol;
    bit row_open;

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] pixval(int r, int c);
        return DATA_W'((r * 73 + c * 11 + 5) & 1023);
    endfunction

    assign adc_data = adc_oe ? pixval(conn, xlat) : 10'h155;

    rolling_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .SETTLE_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_last_row(cfg_last_row),
        .cfg_last_col(cfg_last_col), .cfg_lead(cfg_lead), .cfg_ds_lead(cfg_ds_lead),
        .cfg_ds_en(cfg_ds_en), .dec_addr(dec_addr), .y_load(y_load), .x_load(x_load),
        .row_connect(row_connect), .row_clear(row_clear), .row_clear_ref(row_clear_ref),
        .adc_oe(adc_oe), .adc_data(adc_data), .busy(busy), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_row(pix_row), .pix_col(pix_col),
        .pix_color(pix_color), .pix_sof(pix_sof), .pix_eol(pix_eol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (busy) n_busy++;
        if (y_load) ylat = int'(dec_addr);
        if (x_load) begin
            xlat = int'(dec_addr);
            chk(row_open, "R11 column load outside row", 0, 1);
            chk(xlat == exp_xcol, "R4 column order", xlat, exp_xcol);
            exp_xcol++;
        end
        if (row_connect) begin
            chk(ylat == exp_rrow, "R3 row order", ylat, exp_rrow);
            conn = ylat;
            exp_rrow++;
            exp_xcol = 0;
            row_open = 1;
        end
        if (row_clear) begin
            chk(row_open && exp_xcol == f_cols, "R11 reset before column loop end", exp_xcol, f_cols);
            chk(ylat == (conn + f_lead) % f_rows, "R5 reset row distance", ylat, (conn + f_lead) % f_rows);
            n_clr++;
            row_open = 0;
        end
        if (row_clear_ref) begin
            chk(f_ds == 1, "R6 reference reset while mode off", 1, 0);
            chk(ylat == (conn + f_dslead) % f_rows, "R6 dual reset row", ylat, (conn + f_dslead) % f_rows);
            n_ds++;
        end
        if (pix_valid) begin
            int ec;
            ec = ((exp_pr % 2) == 0) ? (((exp_pc % 2) == 0) ? 0 : 1) : (((exp_pc % 2) == 0) ? 1 : 2);
            chk(pix_data == pixval(exp_pr, exp_pc), "R7 pixel data", int'(pix_data), int'(pixval(exp_pr, exp_pc)));
            chk(int'(pix_row) == exp_pr && int'(pix_col) == exp_pc, "R7 pixel tags",
                int'(pix_row) * 8 + int'(pix_col), exp_pr * 8 + exp_pc);
            chk(int'(pix_color) == ec, "R8 colour tag", int'(pix_color), ec);
            chk(pix_sof == (exp_pr == 0 && exp_pc == 0), "R9 sof", int'(pix_sof), int'(exp_pr == 0 && exp_pc == 0));
            chk(pix_eol == (exp_pc == f_cols - 1), "R9 eol", int'(pix_eol), int'(exp_pc == f_cols - 1));
            if (pix_sof) n_sof++;
            if (pix_eol) n_eol++;
            n_pix++;
            if (exp_pc == f_cols - 1) begin exp_pc = 0; exp_pr++; end
            else exp_pc++;
        end
    end

    task automatic run_frame(input int lr, input int lc, input int ld, input int dl, input int ds, input bit disturb);
        int guard;
        int per;
        f_rows = lr + 1; f_cols = lc + 1; f_lead = ld; f_dslead = dl; f_ds = ds;
        exp_rrow = 0; exp_xcol = 0; exp_pr = 0; exp_pc = 0; row_open = 0;
        n_pix = 0; n_clr = 0; n_ds = 0; n_busy = 0; n_sof = 0; n_eol = 0;
        cfg_last_row = ROW_W'(lr); cfg_last_col = COL_W'(lc);
        cfg_lead = ROW_W'(ld); cfg_ds_lead = ROW_W'(dl); cfg_ds_en = ds[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 busy after start", int'(busy), 1);
        guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (disturb && guard == 7) begin
                // R2: stray start and altered configuration mid-frame
                start = 1'b1;
                cfg_last_col = ~cfg_last_col;
                cfg_ds_en = ~cfg_ds_en;
                cfg_lead = '0;
            end else begin
                start = 1'b0;
            end
        end
        if (guard >= 5000) chk(0, "watchdog expired", guard, 0);
        per = 4 + S + 2 * f_cols + 2 * ds;
        chk(n_busy == f_rows * per, "R10 frame length", n_busy, f_rows * per);
        chk(n_pix == f_rows * f_cols, disturb ? "R2 pixel count" : "R7 pixel count", n_pix, f_rows * f_cols);
        chk(exp_rrow == f_rows, "R3 rows read", exp_rrow, f_rows);
        chk(n_clr == f_rows, "R5 reset count", n_clr, f_rows);
        chk(n_ds == (ds ? f_rows : 0), "R6 dual reset count", n_ds, ds ? f_rows : 0);
        chk(n_sof == 1 && n_eol == f_rows, "R9 marker counts", n_sof * 100 + n_eol, 100 + f_rows);
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !pix_valid, "R2 no queued start", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!y_load && !x_load && !row_connect && !row_clear && !row_clear_ref && !adc_oe && !busy && !pix_valid,
            "R1 reset state", int'({y_load, x_load, row_connect, row_clear, row_clear_ref, adc_oe, busy, pix_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !pix_valid, "R1 idle after reset", int'(busy), 0);
        for (int lr = 1; lr <= 3; lr++)
            for (int lc = 0; lc <= 3; lc++)
                for (int ld = 0; ld <= lr; ld++)
                    for (int ds = 0; ds <= 1; ds++)
                        run_frame(lr, lc, ld, (ld + 1) % (lr + 1), ds, 1'b0);
        run_frame(3, 1, 2, 1, 0, 1'b1);
        run_frame(2, 2, 1, 2, 1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL global watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule